// File: doc/BRIEF.md
# Four-State Hard-Decision Viterbi Decoder

This block recovers message bits from a rate-1/2 convolutional code with memory two (constraint length three). The encoder that feeds it has four trellis states, and for each message bit it sends a pair of channel bits. The decoder takes one received pair per accepted cycle and measures each candidate branch by the Hamming distance. It then runs add-compare-select over the four accumulated path metrics. For each state it keeps the full bit history of the surviving path.

A block begins with a one-cycle `start` pulse. After that the decoder accepts exactly `BLK_LEN` symbols, each one marked by `symValid`; idle cycles between symbols are allowed. It then picks the survivor with the smallest metric and plays that survivor's bits out serially, oldest first, one per cycle. `done` marks the final bit. A new `start` abandons whatever is in progress.

Top module: `viterbi4_decoder`

## Requirements
- R1: After reset, and until a `start` pulse arrives, `outValid` and `done` stay low; `symValid` pulses that arrive before any `start` produce no output.
- R2: The cost of a branch is the number of positions in which `symData` differs from that branch's label. `symData[1]` is the channel bit produced by generator 111 and `symData[0]` is the one produced by generator 101. A path metric is the saturating sum of the branch costs along the path.
- R3: Each block starts in state a with metric zero, and every other state starts unreachable (metric at its maximum).
- R4: State encoding is a=00, b=10, c=01, d=11, with the newest message bit first. Input bit u moves state {r,o} to {u,r}, and the branch label is {u^r^o, u^o}. So a goes to a with label 00 or to b with label 11, and b goes to d with label 01.
- R5: At each state the incoming path with the lower metric survives. On equal metrics, the path from the lower-numbered predecessor survives.
- R6: At the end of a block the decoded word is the history of the state with the lowest metric. On equal metrics, the lowest-numbered state wins.
- R7: A block received without channel errors decodes to exactly the transmitted message bits.
- R8: The decoded bits appear on `outBit` with `outValid` high for `BLK_LEN` consecutive cycles, oldest bit first. The first bit is shown in the cycle after the last symbol is accepted. `done` is high only together with the last bit, and `outValid` falls in the cycle after that.
- R9: Cycles in which `symValid` is low do not change the decoded result.
- R10: `start` restarts decoding from R3 at any time. If it arrives during output, `outValid` is low from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that opens a new block |
| symValid | input | 1 | `symData` holds a symbol to accept this cycle |
| symData | input | 2 | Received channel pair; bit 1 from generator 111, bit 0 from generator 101 |
| outBit | output | 1 | Decoded message bit, oldest first |
| outValid | output | 1 | `outBit` is a decoded bit |
| done | output | 1 | Marks the last decoded bit of the block |

## Verification
An accepted symbol changes the metrics and survivors at the rising edge where `symValid` is sampled. The first decoded bit is therefore visible in the cycle directly after the edge that takes the final symbol, and bit i follows i cycles later. `done` coincides with bit `BLK_LEN-1`. After a `start` pulse during output, `outValid` is low one edge later. The bench drives inputs and samples outputs on the falling edge. It compares each output cycle against that schedule, and compares the whole collected word against an independent forward-push trellis model of the tie rules.

// File: rtl/viterbi4_pkg.sv
package viterbi4_pkg;

  // Strobes from the control FSM into the trellis datapath.
  typedef struct packed {
    logic clr;   // load the start-of-block metrics
    logic step;  // run one add-compare-select step on symData
  } vitStrobe_t;

  // Expected channel pair for input bit u leaving state prev = {newest, older}.
  function automatic logic [1:0] branchLabel(input logic u, input logic [1:0] prev);
    return {u ^ prev[1] ^ prev[0], u ^ prev[0]};
  endfunction

  // Hamming distance between two 2-bit symbols.
  function automatic logic [1:0] symDist(input logic [1:0] a, input logic [1:0] b);
    logic [1:0] x;
    x = a ^ b;
    return {x[1] & x[0], x[1] ^ x[0]};
  endfunction

endpackage

// File: rtl/viterbi4_ctrl.sv
module viterbi4_ctrl
  import viterbi4_pkg::*;
#(
  parameter int BLK_LEN = 8,
  parameter int IW      = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          symValid,
  output vitStrobe_t    strobe,
  output logic [IW-1:0] stepIdx,
  output logic [IW-1:0] readIdx,
  output logic          outValid,
  output logic          done
);

  typedef enum logic [1:0] {IDLE, ACCUM, EMIT} ctrlState_t;

  localparam logic [IW-1:0] LAST = IW'(BLK_LEN - 1);

  ctrlState_t state;
  logic [IW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= IDLE;
      cnt   <= '0;
    end else if (start) begin
      state <= ACCUM;
      cnt   <= '0;
    end else begin
      unique case (state)
        ACCUM: if (symValid) begin
          if (cnt == LAST) begin
            state <= EMIT;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        EMIT: begin
          if (cnt == LAST) begin
            state <= IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe.clr  = start;
    strobe.step = !start && (state == ACCUM) && symValid;
    stepIdx     = cnt;
    readIdx     = cnt;
    outValid    = (state == EMIT);
    done        = (state == EMIT) && (cnt == LAST);
  end

endmodule

// File: rtl/viterbi4_datapath.sv
module viterbi4_datapath
  import viterbi4_pkg::*;
#(
  parameter int BLK_LEN = 8,
  parameter int MW      = 6,
  parameter int IW      = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  vitStrobe_t    strobe,
  input  logic [1:0]    symData,
  input  logic [IW-1:0] stepIdx,
  input  logic [IW-1:0] readIdx,
  output logic          bitOut,
  output logic [MW-1:0] bestMetric
);

  localparam int NS = 4;
  localparam logic [MW-1:0] PM_MAX = '1;

  logic [NS-1:0][MW-1:0]      pm;
  logic [NS-1:0][BLK_LEN-1:0] hist;
  logic [NS-1:0][MW-1:0]      nextPm;
  logic [NS-1:0][BLK_LEN-1:0] nextHist;

  function automatic logic [MW-1:0] satAdd(input logic [MW-1:0] a, input logic [1:0] b);
    logic [MW:0] s;
    s = {1'b0, a} + (MW+1)'(b);
    return s[MW] ? PM_MAX : s[MW-1:0];
  endfunction

  // One add-compare-select unit per destination state {u, r}.
  for (genvar gs = 0; gs < NS; gs++) begin : g_acs
    localparam int U   = gs / 2;
    localparam int R   = gs % 2;
    localparam int PLO = R * 2;
    localparam int PHI = R * 2 + 1;

    logic [1:0]         costLo, costHi;
    logic [MW-1:0]      sumLo, sumHi;
    logic               takeHi;
    logic [BLK_LEN-1:0] merged;

    assign costLo = symDist(symData, branchLabel(1'(U), 2'(PLO)));
    assign costHi = symDist(symData, branchLabel(1'(U), 2'(PHI)));
    assign sumLo  = satAdd(pm[PLO], costLo);
    assign sumHi  = satAdd(pm[PHI], costHi);
    assign takeHi = sumHi < sumLo;

    always_comb begin
      merged          = takeHi ? hist[PHI] : hist[PLO];
      merged[stepIdx] = 1'(U);
    end

    assign nextPm[gs]   = takeHi ? sumHi : sumLo;
    assign nextHist[gs] = merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pm   <= {NS{PM_MAX}};
      hist <= '0;
    end else if (strobe.clr) begin
      pm    <= {NS{PM_MAX}};
      pm[0] <= '0;
      hist  <= '0;
    end else if (strobe.step) begin
      pm   <= nextPm;
      hist <= nextHist;
    end
  end

  // Lowest metric wins; the first (lowest-numbered) state keeps a tie.
  logic [1:0] bestIdx;
  always_comb begin
    bestIdx    = 2'd0;
    bestMetric = pm[0];
    for (int i = 1; i < NS; i++) begin
      if (pm[i] < bestMetric) begin
        bestMetric = pm[i];
        bestIdx    = 2'(i);
      end
    end
  end

  assign bitOut = hist[bestIdx][readIdx];

endmodule

// File: rtl/viterbi4_decoder.sv
module viterbi4_decoder
  import viterbi4_pkg::*;
#(
  parameter int BLK_LEN = 8,
  parameter int MW      = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       symValid,
  input  logic [1:0] symData,
  output logic       outBit,
  output logic       outValid,
  output logic       done
);

  localparam int IW = (BLK_LEN > 1) ? $clog2(BLK_LEN) : 1;

  vitStrobe_t    strobe;
  logic [IW-1:0] stepIdx, readIdx;
  logic [MW-1:0] bestMetric;
  logic          stepS, clrS;

  assign stepS = strobe.step;
  assign clrS  = strobe.clr;

  viterbi4_ctrl #(.BLK_LEN(BLK_LEN), .IW(IW)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .symValid(symValid),
    .strobe(strobe), .stepIdx(stepIdx), .readIdx(readIdx),
    .outValid(outValid), .done(done)
  );

  viterbi4_datapath #(.BLK_LEN(BLK_LEN), .MW(MW), .IW(IW)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .symData(symData),
    .stepIdx(stepIdx), .readIdx(readIdx),
    .bitOut(outBit), .bestMetric(bestMetric)
  );

endmodule

// File: rtl/viterbi4_chk.sv
module viterbi4_chk #(
  parameter int MW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          outValid,
  input logic          done,
  input logic          stepS,
  input logic          clrS,
  input logic [MW-1:0] bestMetric
);

  // R8: done only marks a decoded bit
  p_done_with_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> outValid);

  // R8: output stops right after the last bit
  p_end_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> !outValid);

  // R8: bits come in an unbroken run
  p_unbroken_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !done && !start |=> outValid);

  // R10: start cuts off output
  p_start_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !outValid);

  // R3: a fresh block has a zero-metric survivor
  p_fresh_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clrS |=> bestMetric == '0);

  // R2: best metric never drops and rises by at most two per step
  p_metric_grow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stepS |=> ({1'b0, bestMetric} >= {1'b0, $past(bestMetric)}) &&
              ({1'b0, bestMetric} <= {1'b0, $past(bestMetric)} + (MW+1)'(2)));

endmodule

bind viterbi4_decoder viterbi4_chk #(.MW(MW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .outValid(outValid), .done(done),
  .stepS(stepS), .clrS(clrS), .bestMetric(bestMetric)
);

// File: tb/viterbi4_decoder_tb_top.sv
module viterbi4_decoder_tb_top;

  localparam int BLK = 8;
  localparam int NV  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic symValid = 1'b0;
  logic [1:0] symData = 2'b00;
  logic outBit, outValid, done;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  viterbi4_decoder #(.BLK_LEN(BLK), .MW(6)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .symValid(symValid),
    .symData(symData), .outBit(outBit), .outValid(outValid), .done(done)
  );

  localparam logic [BLK-1:0]   MSG_T [NV] = '{8'h00, 8'hFF, 8'hA5, 8'h3C,
                                             8'h5A, 8'hC3, 8'h00, 8'h96};
  localparam logic [2*BLK-1:0] ERR_T [NV] = '{16'h0000, 16'h0000, 16'h0000, 16'h0000,
                                             16'h0010, 16'h0200, 16'hAAAA, 16'h0C03};

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Convolutional encoder: bit k of msg is sent at symbol k.
  function automatic logic [2*BLK-1:0] encode(input logic [BLK-1:0] msg);
    logic newest, older;
    logic [2*BLK-1:0] rx;
    newest = 1'b0; older = 1'b0; rx = '0;
    for (int k = 0; k < BLK; k++) begin
      rx[2*k+1] = msg[k] ^ newest ^ older;
      rx[2*k]   = msg[k] ^ older;
      older  = newest;
      newest = msg[k];
    end
    return rx;
  endfunction

  // Forward-push trellis model built from R2..R6.
  function automatic logic [BLK-1:0] refDecode(input logic [2*BLK-1:0] rx);
    int pmv[4], npm[4];
    logic [BLK-1:0] h[4], nh[4];
    int best;
    pmv = '{0, 999, 999, 999};
    for (int s = 0; s < 4; s++) h[s] = '0;
    for (int k = 0; k < BLK; k++) begin
      for (int s = 0; s < 4; s++) begin npm[s] = 100000; nh[s] = '0; end
      for (int p = 0; p < 4; p++) begin
        for (int u = 0; u < 2; u++) begin
          int r, o, ns, d, c;
          r  = p / 2;
          o  = p % 2;
          ns = u * 2 + r;
          d  = (((u ^ r ^ o) & 1) != int'(rx[2*k+1]) ? 1 : 0) +
               (((u ^ o) & 1) != int'(rx[2*k]) ? 1 : 0);
          c  = pmv[p] + d;
          if (c < npm[ns]) begin
            npm[ns] = c;
            nh[ns]  = h[p];
            nh[ns][k] = 1'(u);
          end
        end
      end
      pmv = npm;
      h   = nh;
    end
    best = 0;
    for (int s = 1; s < 4; s++) if (pmv[s] < pmv[best]) best = s;
    return h[best];
  endfunction

  task automatic feed(input logic [2*BLK-1:0] rx, input int n, input int gap);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int k = 0; k < n; k++) begin
      symData  = rx[2*k +: 2];
      symValid = 1'b1;
      @(negedge clk);
      symValid = 1'b0;
      symData  = 2'b00;
      if (k != n - 1) repeat (gap) @(negedge clk);
    end
  endtask

  // Called at the falling edge right after the final symbol was accepted.
  task automatic collect(output logic [BLK-1:0] word, output bit shapeOk);
    shapeOk = 1'b1;
    word = '0;
    for (int i = 0; i < BLK; i++) begin
      if (outValid !== 1'b1 || done !== (i == BLK - 1)) shapeOk = 1'b0;
      word[i] = outBit;
      @(negedge clk);
    end
    if (outValid !== 1'b0) shapeOk = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL R8 watchdog actual=hang expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [BLK-1:0] word, exp;
    logic [2*BLK-1:0] rx;
    bit shapeOk;
    bit quiet;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0 && done == 1'b0, "R1 reset outputs", {30'b0, outValid, done}, 32'h0);

    // R1: symbols before any start are ignored
    quiet = 1'b1;
    symData = 2'b11;
    symValid = 1'b1;
    repeat (12) begin
      @(negedge clk);
      if (outValid !== 1'b0 || done !== 1'b0) quiet = 1'b0;
    end
    symValid = 1'b0;
    repeat (3) begin
      @(negedge clk);
      if (outValid !== 1'b0) quiet = 1'b0;
    end
    check(quiet, "R1 no output without start", {31'b0, quiet}, 32'h1);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      rx  = encode(MSG_T[v]) ^ ERR_T[v];
      exp = refDecode(rx);
      feed(rx, BLK, 0);
      collect(word, shapeOk);
      check(shapeOk, "R8 output timing", {31'b0, shapeOk}, 32'h1);
      check(word == exp, "R2 R4 R5 R6 decoded word", 32'(word), 32'(exp));
      if (ERR_T[v] == '0)
        check(word == MSG_T[v], "R7 clean block", 32'(word), 32'(MSG_T[v]));
    end

    // R3: worked trellis example (11 01 01 10 01 then zeros)
    rx  = 16'h0197;
    exp = refDecode(rx);
    feed(rx, BLK, 0);
    collect(word, shapeOk);
    check(word == exp, "R3 R4 example sequence", 32'(word), 32'(exp));

    // R9: idle gaps between symbols
    rx  = encode(8'h6D) ^ 16'h0040;
    exp = refDecode(rx);
    feed(rx, BLK, 3);
    collect(word, shapeOk);
    check(shapeOk, "R9 gapped timing", {31'b0, shapeOk}, 32'h1);
    check(word == exp, "R9 gapped word", 32'(word), 32'(exp));

    // R10: restart in mid-accumulation
    feed(encode(8'hFF) ^ 16'h5555, 3, 0);
    rx  = encode(8'h2B);
    feed(rx, BLK, 0);
    collect(word, shapeOk);
    check(word == 8'h2B && shapeOk, "R10 restart mid-block", 32'(word), 32'h2B);

    // R10: start during output
    feed(encode(8'h81), BLK, 0);
    repeat (3) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(outValid == 1'b0, "R10 abort output", {31'b0, outValid}, 32'h0);
    rx  = encode(8'hE4);
    feed(rx, BLK, 0);
    collect(word, shapeOk);
    check(word == 8'hE4 && shapeOk, "R10 block after abort", 32'(word), 32'hE4);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule